// File: doc/BRIEF.md
# NAND Page Buffer and Array Engine

This block is the storage core behind a NAND-style command decoder. It owns a small on-chip flash array, organised as pages that each carry a spare area of one thirty-second of the page size. It also owns one page register, which both reads and programs use. The decoder supplies single-cycle start pulses, a combined row/column address and a pre-loaded column offset. The engine then copies a page into the register for sequential byte reads, collects host program bytes into the register and commits them to the array, or erases a whole block to 0xFF.

Transfers between the array and the register move one byte per clock, and `busy` is high while a transfer runs. The byte-wide data-in and data-out paths are gated by an active-low chip enable. Data-out is registered: the byte requested by a `dout_re` cycle appears on `dout` after the next rising edge.

Top module: `nand_page_engine`

## Requirements
- R1: Each page row holds PAGE_BYTES + PAGE_BYTES/32 bytes. With the default 64-byte page this is 2 spare bytes at columns 64 and 65, and a read with `spare_en` high can reach both of them.
- R2: After a `prog_go` pulse, each `din_we` cycle with `ce_n`, `cle` and `ale` all low stores `din` at the next register position, starting at 0. Once the row size is reached, further bytes are dropped. A `din_we` cycle with `ce_n`, `cle` or `ale` high stores nothing.
- R3: The row sits in `addr[ADDR_W-1:COL_W]` and the column in `addr[COL_W-1:0]`. On `rd_go` the read starts at column + offset, and the offset is cleared. With `spare_en` high the readable length is row size − start; with it low the length is PAGE_BYTES − start. A negative length reads as 0.
- R4: A `dout_re` cycle puts 0 on `dout` when `ce_n` is high, when `busy` is high or when no bytes remain, and in that case the read position does not advance. Otherwise it puts the next byte on `dout` and advances the position by one.
- R5: An erase takes the row from `addr[ROW_W-1:0]`. It forms the byte address as row << COL_W, where COL_W is 8 in small-page mode and 16 in large-page mode. It then aligns that page down to a multiple of PAGES_PER_BLK.
- R6: An erase sets every byte of the block's pages to 0xFF, spare bytes included, and leaves other blocks unchanged.
- R7: A read, program or erase whose page index is PAGES_PER_BLK*NUM_BLKS or more changes nothing in the array. Such a read yields 0 bytes, and such an erase never raises `busy`.
- R8: After reset every array byte is 0xFF, `dout` is 0 and `busy` is low.
- R9: `commit_go` writes the collected bytes into the array starting at column + offset. Any byte that would fall past the end of the row is discarded, and the offset is then cleared.
- R10: `busy` stays high for one cycle per byte moved: row size − start cycles for a read, PAGES_PER_BLK × row size cycles for an erase. Start pulses and offset writes arriving while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable gating data-in and data-out |
| cle | input | 1 | Command latch strobe; data-in is not stored while high |
| ale | input | 1 | Address latch strobe; data-in is not stored while high |
| spare_en | input | 1 | Include the spare area in the read length |
| addr | input | ADDR_W | Row and column address (row only, low bits, for erase) |
| ofs_in | input | OFS_W | Column offset value |
| ofs_wr | input | 1 | Load `ofs_in` into the offset register |
| rd_go | input | 1 | Start a page load for reading |
| prog_go | input | 1 | Start collecting program bytes |
| commit_go | input | 1 | Commit collected bytes to the array |
| erase_go | input | 1 | Erase the block holding the addressed row |
| din | input | 8 | Program data byte |
| din_we | input | 1 | Data-in strobe |
| dout_re | input | 1 | Data-out strobe |
| dout | output | 8 | Registered read data |
| busy | output | 1 | Array transfer in progress |

## Verification
Reads are tried at column 0, at a mid-page column, inside the spare area, past the row end, and on a page outside the array. Each is run with the spare area both included and excluded, so errors in the start position, the length arithmetic and the range check each show up differently. Programs use full rows, over-long streams, short bursts at an offset column and bursts that run off the row end; these separate the capture limit from the commit clipping. Erases started from a middle row of a block prove the alignment and the spare clearing. Two neighbouring pages with distinct data expose an erase that overruns its block.

// File: rtl/nand_pe_pkg.sv
// Shared types for the NAND page engine.
package nand_pe_pkg;
    typedef logic [7:0] byte_t;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT,
        ST_ERASE
    } eng_state_e;
endpackage

// File: rtl/nand_pe_array.sv
// Flash cell array: flat byte store holding every page row back to back.
// Assumes one write per cycle; read is combinational. Reset fills it
// with 0xFF, the erased value.
module nand_pe_array
    import nand_pe_pkg::*;
#(
    parameter int DEPTH = 1056,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    byte_t mem [DEPTH];

    // Storage update: erased on reset, otherwise one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we && (waddr < AW'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port; addresses beyond the array read as erased.
    assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : 8'hFF;
endmodule

// File: rtl/nand_pe_pagereg.sv
// Page register: one row-sized byte buffer shared by reads and programs.
// Assumes the controller never writes and reads the same index with
// conflicting intent in one cycle.
module nand_pe_pagereg
    import nand_pe_pkg::*;
#(
    parameter int ROW_BYTES = 66,
    parameter int IW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  byte_t         wdata,
    input  logic [IW-1:0] ridx,
    output byte_t         rdata
);
    byte_t buf_q [ROW_BYTES];

    // Buffer write: cleared on reset, one byte per cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_BYTES; i++) buf_q[i] <= 8'h00;
        end else if (we && (widx < IW'(ROW_BYTES))) begin
            buf_q[widx] <= wdata;
        end
    end

    // Read port with out-of-range guard.
    assign rdata = (ridx < IW'(ROW_BYTES)) ? buf_q[ridx] : 8'h00;
endmodule

// File: rtl/nand_pe_ctrl.sv
// Engine controller: accepts start pulses, tracks the offset, the program
// fill level and the read position, and sequences byte-per-cycle moves
// between array and page register. Assumes PAGES_PER_BLK is a power of two
// and that start pulses are one cycle wide.
module nand_pe_ctrl
    import nand_pe_pkg::*;
#(
    parameter int PAGE_BYTES    = 64,
    parameter int PAGES_PER_BLK = 4,
    parameter int NUM_BLKS      = 4,
    parameter int COL_W         = 8,
    parameter int ROW_W         = 8,
    parameter int ADDR_W        = ROW_W + COL_W,
    parameter int OFS_W         = COL_W + 1,
    parameter int AW            = 11,
    parameter int IW            = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              spare_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic              ofs_wr,
    input  logic              rd_go,
    input  logic              prog_go,
    input  logic              commit_go,
    input  logic              erase_go,
    input  byte_t             din,
    input  logic              din_we,
    input  logic              dout_re,
    output byte_t             dout,
    output logic              busy,
    // array side
    output logic              arr_we,
    output logic [AW-1:0]     arr_addr,
    output byte_t             arr_wdata,
    input  byte_t             arr_rdata,
    // page register side
    output logic              preg_we,
    output logic [IW-1:0]     preg_widx,
    output byte_t             preg_wdata,
    output logic [IW-1:0]     preg_ridx,
    input  byte_t             preg_rdata
);
    localparam int SPARE     = PAGE_BYTES / 32;
    localparam int TOTAL     = PAGE_BYTES + SPARE;
    localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
    localparam int BLK_BYTES = PAGES_PER_BLK * TOTAL;
    localparam int XW        = $clog2(BLK_BYTES + 1);
    localparam int SW        = COL_W + 2;

    eng_state_e        state_q;
    logic [XW-1:0]     xfer_q, xend_q;
    logic [AW-1:0]     base_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [IW-1:0]     fill_q, rd_ptr_q, rd_left_q;
    logic              prog_q;
    byte_t             dout_q;

    logic [ROW_W-1:0]  row_f, erow, epage, eblk_page;
    logic [COL_W-1:0]  col_f;
    logic [ADDR_W-1:0] efull;
    logic [SW-1:0]     start_s, lim_s, rd_len_s, room_s, commit_n;
    logic              page_ok, start_in, erase_ok, idle, host_wr, rd_take;
    logic [AW-1:0]     row_base, eblk_base;

    // Address decode for read and program: row above, column below.
    always_comb begin
        row_f    = addr[ADDR_W-1:COL_W];
        col_f    = addr[COL_W-1:0];
        start_s  = SW'(col_f) + SW'(ofs_q);
        page_ok  = 32'(row_f) < NUM_PAGES;
        start_in = start_s < SW'(TOTAL);
        lim_s    = spare_en ? SW'(TOTAL) : SW'(PAGE_BYTES);
        rd_len_s = (start_s < lim_s) ? (lim_s - start_s) : '0;
        room_s   = start_in ? (SW'(TOTAL) - start_s) : '0;
        commit_n = (SW'(fill_q) < room_s) ? SW'(fill_q) : room_s;
        row_base = AW'(row_f) * AW'(TOTAL);
    end

    // Erase decode: row shifted to a byte address, then block-aligned.
    always_comb begin
        erow      = addr[ROW_W-1:0];
        efull     = {erow, {COL_W{1'b0}}};
        epage     = ROW_W'(efull >> COL_W);
        eblk_page = epage & ~ROW_W'(PAGES_PER_BLK - 1);
        erase_ok  = 32'(epage) < NUM_PAGES;
        eblk_base = AW'(eblk_page) * AW'(TOTAL);
    end

    // Host strobes qualified by chip enable, latch strobes and state.
    always_comb begin
        idle    = (state_q == ST_IDLE);
        host_wr = idle && prog_q && din_we && !ce_n && !cle && !ale &&
                  (fill_q < IW'(TOTAL));
        rd_take = idle && dout_re && !ce_n && (rd_left_q != '0);
    end

    // Datapath steering between host, page register and array.
    always_comb begin
        arr_addr   = base_q + AW'(xfer_q);
        arr_we     = (state_q == ST_COMMIT) || (state_q == ST_ERASE);
        arr_wdata  = (state_q == ST_ERASE) ? 8'hFF : preg_rdata;
        preg_we    = (state_q == ST_LOAD) || host_wr;
        preg_widx  = (state_q == ST_LOAD) ? IW'(xfer_q) : fill_q;
        preg_wdata = (state_q == ST_LOAD) ? arr_rdata : din;
        preg_ridx  = (state_q == ST_COMMIT) ? IW'(xfer_q) : rd_ptr_q;
    end

    // Control sequencer: start pulses in IDLE, byte loop elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            xfer_q    <= '0;
            xend_q    <= '0;
            base_q    <= '0;
            ofs_q     <= '0;
            fill_q    <= '0;
            prog_q    <= 1'b0;
            rd_ptr_q  <= '0;
            rd_left_q <= '0;
        end else if (idle) begin
            if (host_wr) fill_q <= fill_q + 1'b1;
            if (rd_take) begin
                rd_ptr_q  <= rd_ptr_q + 1'b1;
                rd_left_q <= rd_left_q - 1'b1;
            end
            if (erase_go) begin
                prog_q <= 1'b0;
                if (erase_ok) begin
                    base_q  <= eblk_base;
                    xfer_q  <= '0;
                    xend_q  <= XW'(BLK_BYTES - 1);
                    state_q <= ST_ERASE;
                end
            end else if (commit_go) begin
                prog_q <= 1'b0;
                fill_q <= '0;
                ofs_q  <= '0;
                if (page_ok && start_in && (fill_q != '0)) begin
                    base_q  <= row_base + AW'(start_s);
                    xfer_q  <= '0;
                    xend_q  <= XW'(commit_n - 1'b1);
                    state_q <= ST_COMMIT;
                end
            end else if (rd_go) begin
                prog_q    <= 1'b0;
                ofs_q     <= '0;
                rd_ptr_q  <= '0;
                rd_left_q <= page_ok ? IW'(rd_len_s) : '0;
                if (page_ok && start_in) begin
                    base_q  <= row_base + AW'(start_s);
                    xfer_q  <= '0;
                    xend_q  <= XW'(room_s - 1'b1);
                    state_q <= ST_LOAD;
                end
            end else if (prog_go) begin
                prog_q <= 1'b1;
                fill_q <= '0;
            end else if (ofs_wr) begin
                ofs_q <= ofs_in;
            end
        end else begin
            if (xfer_q == xend_q) state_q <= ST_IDLE;
            else                  xfer_q  <= xfer_q + 1'b1;
        end
    end

    // Registered data-out: next byte, or 0 when gated or exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= 8'h00;
        else if (dout_re) dout_q <= rd_take ? preg_rdata : 8'h00;
    end

    assign dout = dout_q;
    assign busy = !idle;

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= IW'(TOTAL));

    // R4
    dout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_re && ce_n) |=> (dout == 8'h00));

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_re && !ce_n && idle && (rd_left_q != '0) && !rd_go)
        |=> (rd_left_q == $past(rd_left_q) - 1'b1));

    // R3
    ofs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rd_go && !erase_go && !commit_go) |=> (ofs_q == '0));

    // R7
    erase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && erase_go && !erase_ok) |=> !busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ofs_wr) |=> $stable(ofs_q));
endmodule

// File: rtl/nand_page_engine.sv
// Top of the NAND page engine: wires the controller to the cell array and
// the page register. Assumes PAGE_BYTES is a multiple of 32 and
// PAGES_PER_BLK a power of two. COL_W, ADDR_W and OFS_W are derived and
// are not meant to be overridden.
module nand_page_engine
    import nand_pe_pkg::*;
#(
    parameter int PAGE_BYTES    = 64,
    parameter int PAGES_PER_BLK = 4,
    parameter int NUM_BLKS      = 4,
    parameter int LARGE_PAGE    = 0,
    parameter int ROW_W         = 8,
    parameter int COL_W         = (LARGE_PAGE != 0) ? 16 : 8,
    parameter int ADDR_W        = ROW_W + COL_W,
    parameter int OFS_W         = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              spare_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic              ofs_wr,
    input  logic              rd_go,
    input  logic              prog_go,
    input  logic              commit_go,
    input  logic              erase_go,
    input  logic [7:0]        din,
    input  logic              din_we,
    input  logic              dout_re,
    output logic [7:0]        dout,
    output logic              busy
);
    localparam int TOTAL     = PAGE_BYTES + PAGE_BYTES / 32;
    localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
    localparam int DEPTH     = NUM_PAGES * TOTAL;
    localparam int AW        = $clog2(DEPTH);
    localparam int IW        = $clog2(TOTAL + 1);

    logic          arr_we, preg_we;
    logic [AW-1:0] arr_addr;
    byte_t         arr_wdata, arr_rdata, preg_wdata, preg_rdata;
    logic [IW-1:0] preg_widx, preg_ridx;

    nand_pe_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLK(PAGES_PER_BLK),
        .NUM_BLKS(NUM_BLKS), .COL_W(COL_W), .ROW_W(ROW_W),
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .AW(AW), .IW(IW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .spare_en(spare_en), .addr(addr), .ofs_in(ofs_in), .ofs_wr(ofs_wr),
        .rd_go(rd_go), .prog_go(prog_go), .commit_go(commit_go),
        .erase_go(erase_go), .din(din), .din_we(din_we), .dout_re(dout_re),
        .dout(dout), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata),
        .preg_we(preg_we), .preg_widx(preg_widx), .preg_wdata(preg_wdata),
        .preg_ridx(preg_ridx), .preg_rdata(preg_rdata)
    );

    nand_pe_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr),
        .wdata(arr_wdata), .raddr(arr_addr), .rdata(arr_rdata)
    );

    nand_pe_pagereg #(.ROW_BYTES(TOTAL), .IW(IW)) u_preg (
        .clk(clk), .rst_n(rst_n), .we(preg_we), .widx(preg_widx),
        .wdata(preg_wdata), .ridx(preg_ridx), .rdata(preg_rdata)
    );
endmodule

// File: tb/nand_page_engine_tb.sv
module nand_page_engine_tb;
    localparam int PG = 64, TOT = 66, PPB = 4, NP = 16;
    localparam int OP_RD = 0, OP_PROG = 1, OP_COMMIT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, spare_en = 1'b1;
    logic [15:0] addr = '0;
    logic [8:0]  ofs_in = '0;
    logic ofs_wr = 0, rd_go = 0, prog_go = 0, commit_go = 0, erase_go = 0;
    logic [7:0] din = '0;
    logic din_we = 0, dout_re = 0;
    logic [7:0] dout;
    logic busy;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] bm [NP][TOT];

    always #5 clk = ~clk;

    nand_page_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .spare_en(spare_en), .addr(addr), .ofs_in(ofs_in), .ofs_wr(ofs_wr),
        .rd_go(rd_go), .prog_go(prog_go), .commit_go(commit_go),
        .erase_go(erase_go), .din(din), .din_we(din_we), .dout_re(dout_re),
        .dout(dout), .busy(busy)
    );

    // read vectors: page, column, offset, spare_en, requirement (1/3/7)
    localparam int RV [7][5] = '{
        '{0, 0, 0, 1, 3}, '{2, 10, 0, 1, 3}, '{3, 0, 64, 1, 1},
        '{1, 5, 3, 0, 3}, '{2, 0, 0, 0, 3}, '{0, 70, 0, 1, 3},
        '{20, 0, 0, 1, 7}
    };

    function automatic logic [7:0] pat(int s, int k);
        return 8'(((s * 37 + k * 3) % 255) + 1);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic pulse_op(int op, int row, int col);
        addr = 16'((row << 8) | (col & 255));
        rd_go = (op == OP_RD); prog_go = (op == OP_PROG); commit_go = (op == OP_COMMIT);
        @(negedge clk);
        rd_go = 0; prog_go = 0; commit_go = 0;
    endtask

    task automatic erase_start(int row);
        addr = 16'(row); erase_go = 1;
        @(negedge clk);
        erase_go = 0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
    endtask

    task automatic set_ofs(int v);
        ofs_in = 9'(v); ofs_wr = 1;
        @(negedge clk);
        ofs_wr = 0;
    endtask

    task automatic read_one(output logic [7:0] b);
        dout_re = 1;
        @(negedge clk);
        dout_re = 0;
        b = dout;
    endtask

    task automatic check_read(int p, int col, int ofs, int sp, string req);
        int c, st, lim, len, ea, aa;
        bit bad;
        logic [7:0] b;
        if (ofs != 0) set_ofs(ofs);
        spare_en = sp[0];
        pulse_op(OP_RD, p, col);
        wait_idle(c);
        st = col + ofs; lim = sp ? TOT : PG;
        len = (p < NP && st < lim) ? lim - st : 0;
        bad = 0; ea = 0; aa = 0;
        for (int k = 0; k < len; k++) begin
            read_one(b);
            if (!bad && b !== bm[p][st + k]) begin bad = 1; aa = b; ea = bm[p][st + k]; end
        end
        chk(!bad, req, $sformatf("data page %0d col %0d", p, st), aa, ea);
        read_one(b);
        chk(b == 0, req, $sformatf("end of data page %0d", p), b, 0);
        spare_en = 1;
    endtask

    task automatic program_page(int p, int col, int ofs, int n, int seed);
        int c, st;
        if (ofs != 0) set_ofs(ofs);
        pulse_op(OP_PROG, p, col);
        for (int k = 0; k < n; k++) begin
            din = pat(seed, k); din_we = 1;
            @(negedge clk);
        end
        din_we = 0;
        pulse_op(OP_COMMIT, p, col);
        wait_idle(c);
        st = col + ofs;
        if (p < NP)
            for (int k = 0; k < n && k < TOT; k++)
                if (st + k < TOT) bm[p][st + k] = pat(seed, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        logic [7:0] b;
        for (int p = 0; p < NP; p++) for (int i = 0; i < TOT; i++) bm[p][i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(dout == 0, "R8", "dout after reset", dout, 0);
        chk(busy == 0, "R8", "busy after reset", busy, 0);

        // erased contents and load duration
        pulse_op(OP_RD, 0, 0);
        wait_idle(c);
        chk(c == TOT, "R10", "load busy cycles", c, TOT);
        check_read(0, 0, 0, 1, "R8");

        // fill pages; page 1 gets an over-long stream (R2)
        program_page(0, 0, 0, TOT, 1);
        program_page(1, 0, 0, TOT + 4, 2);
        program_page(2, 0, 0, TOT, 3);
        program_page(3, 0, 0, TOT, 4);
        program_page(4, 0, 0, TOT, 5);
        check_read(1, 0, 0, 1, "R2");

        // vector table walk
        for (int v = 0; v < 7; v++) begin
            case (RV[v][4])
                1:       check_read(RV[v][0], RV[v][1], RV[v][2], RV[v][3], "R1");
                7:       check_read(RV[v][0], RV[v][1], RV[v][2], RV[v][3], "R7");
                default: check_read(RV[v][0], RV[v][1], RV[v][2], RV[v][3], "R3");
            endcase
        end

        // offset consumed by one read only (R3)
        check_read(2, 0, 4, 1, "R3");
        check_read(2, 0, 0, 1, "R3");

        // partial program at column + offset, and clipping at row end (R9)
        program_page(5, 10, 2, 3, 6);
        check_read(5, 0, 0, 1, "R9");
        program_page(6, 60, 0, 10, 7);
        check_read(6, 0, 0, 1, "R9");
        program_page(7, 0, 5, 2, 8);
        program_page(7, 20, 0, 2, 9);
        check_read(7, 0, 0, 1, "R9");

        // out-of-range program must not touch any page (R7)
        program_page(16, 0, 0, TOT, 10);
        check_read(0, 0, 0, 1, "R7");

        // data-in gating (R2)
        pulse_op(OP_PROG, 10, 0);
        ce_n = 1; din = 8'h11; din_we = 1; @(negedge clk);
        ce_n = 0; cle = 1; din = 8'h22; @(negedge clk);
        cle = 0; ale = 1; din = 8'h33; @(negedge clk);
        ale = 0; din = 8'h44; @(negedge clk);
        din_we = 0;
        pulse_op(OP_COMMIT, 10, 0);
        wait_idle(c);
        bm[10][0] = 8'h44;
        check_read(10, 0, 0, 1, "R2");

        // data-out gating without advance (R4)
        pulse_op(OP_RD, 10, 0);
        wait_idle(c);
        ce_n = 1; read_one(b); ce_n = 0;
        chk(b == 0, "R4", "dout with ce_n high", b, 0);
        read_one(b);
        chk(b == 8'h44, "R4", "first byte after gated read", b, 8'h44);
        read_one(b);
        chk(b == 8'hFF, "R4", "second byte", b, 8'hFF);

        // erase from a middle row of block 0 (R5, R6, R10)
        erase_start(1);
        wait_idle(c);
        chk(c == PPB * TOT, "R10", "erase busy cycles", c, PPB * TOT);
        for (int p = 0; p < 4; p++) for (int i = 0; i < TOT; i++) bm[p][i] = 8'hFF;
        check_read(0, 0, 0, 1, "R5");
        check_read(3, 0, 0, 1, "R6");
        check_read(4, 0, 0, 1, "R6");

        // out-of-range erase (R7)
        erase_start(16);
        chk(busy == 0, "R7", "busy after out-of-range erase", busy, 0);
        check_read(5, 0, 0, 1, "R7");

        // offset write ignored during an erase of block 2 (R10)
        erase_start(9);
        set_ofs(6);
        wait_idle(c);
        for (int p = 8; p < 12; p++) for (int i = 0; i < TOT; i++) bm[p][i] = 8'hFF;
        check_read(5, 0, 0, 1, "R10");
        check_read(10, 0, 0, 1, "R6");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule